// File: doc/BRIEF.md
# Daisy-Chain Serial Configuration Receiver

This block is the serial front end of one device in a chain of devices that take their configuration over a single shared bit stream. Bits arrive on a serial input that is sampled on the rising edge of the configuration clock. Bits leave on a serial output that changes on the falling edge. The next device in the chain therefore sees each forwarded bit half a clock after this device took it in.

While idle, the block watches the input for a fixed 8-bit start pattern. It then captures a 24-bit length count that gives the number of bits in the stream for the whole chain, counted from the first bit of the count itself. It forwards the start pattern and the count unchanged, so every device further down receives them. Next it fills its own frame store. Each frame is a short field of zero-valued start bits followed by a data word. While it fills the store it holds its output high, so devices further down never see a frame start too early. Once its store is full it becomes a pass-through and forwards every bit until its counter reaches the length count. It then raises a sticky done flag, holds its output high and ignores the input until the next reset.

An active-low synchronous reset plays the part of the program pin. A read port exposes the frame store to the fabric that uses it.

Top module: `cfg_chain_rx`

## Requirements
- R1: Each input bit is sampled on a rising clock edge. When the block forwards that bit, it appears on `sdo` after the next falling edge and stays there until the falling edge after that.
- R2: While searching, the block compares a sliding window of the last 8 input bits, newest bit last, against the pattern 1111_0010. A window that differs in any bit does not start reception. Every bit received while searching, including the pattern itself, is forwarded.
- R3: The 24 bits that follow the pattern are taken as the length count, most significant bit first, and each of them is forwarded.
- R4: The received-bit counter counts 1 at the first length bit and advances by one per bit. When it equals the length count, `done` goes high after that bit's rising edge. If the count is 24 or less, `done` goes high at the last length bit.
- R5: After the length count, bits are grouped into frames of START_BITS zero start bits followed by FRAME_DATA data bits, most significant bit first. The k-th frame received is stored in entry k. `sdo` is high for every bit of these frames.
- R6: When all NUM_FRAMES entries are filled and the counter is still below the length count, every further bit is forwarded on `sdo` until the counter reaches the length count.
- R7: Once `done` is high, it stays high and `sdo` stays high. Further input has no effect, and this includes a repeat of the start pattern.
- R8: While `prog_n` is low at a rising edge, the block clears `done`, the counter and every frame entry and returns to the search. `sdo` reads 1 after the next falling edge.
- R9: `rd_frame` shows frame entry `rd_sel` without a clock delay. An entry that was never completely received reads 0.
- R10: If the counter reaches the length count before the frame store is full, the block finishes at once. The frame that was only partly received is not written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cclk | input | 1 | Configuration clock; input sampled on rising edge, output driven on falling edge |
| prog_n | input | 1 | Active-low synchronous reset (program request) |
| sdi | input | 1 | Serial configuration data in |
| rd_sel | input | SEL_W | Frame store entry to read |
| sdo | output | 1 | Serial configuration data out to the next device |
| done | output | 1 | Sticky flag: length count reached |
| rd_frame | output | FRAME_DATA | Data word of the selected frame entry |

## Verification
The bench builds the block with FRAME_DATA=4, START_BITS=2 and NUM_FRAMES=3, so the local store holds only 18 bits. The 24-bit length field and the 8-bit start pattern keep their default sizes. This makes it practical to sweep the length count over every value from 20 to 48. The sweep covers counts at or below the length field size, counts that end inside each frame or on a frame boundary, a count that ends exactly when the store fills, and several counts that need pass-through. Some runs start with a near-miss pattern. Each run ends with a repeated start pattern after completion, and one run is cut short by a reset after a frame has been written.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;

  typedef enum logic [2:0] {
    ST_SEARCH,
    ST_LENGTH,
    ST_LOAD,
    ST_PASS,
    ST_FINISHED
  } rx_state_e;

  // Total bits occupied by one local frame on the wire.
  function automatic int frame_bits(input int start_bits, input int data_bits);
    return start_bits + data_bits;
  endfunction

  // Value to present downstream for a bit taken in while in state s.
  function automatic logic fwd_value(input rx_state_e s, input logic b);
    if (s == ST_LOAD || s == ST_FINISHED) return 1'b1;
    return b;
  endfunction

endpackage

// File: rtl/cfg_preamble_det.sv
module cfg_preamble_det #(
  parameter int PRE_BITS = 8,
  parameter logic [PRE_BITS-1:0] PATTERN = 8'hF2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic bit_in,
  output logic hit
);
  logic [PRE_BITS-1:0] win_q;
  logic [PRE_BITS-1:0] win_d;

  assign win_d = {win_q[PRE_BITS-2:0], bit_in};
  assign hit   = enable && (win_d == PATTERN);

  always_ff @(posedge clk) begin
    if (!rst_n)         win_q <= '0;
    else if (hit)       win_q <= '0;
    else if (enable)    win_q <= win_d;
  end
endmodule

// File: rtl/cfg_frame_loader.sv
module cfg_frame_loader
  import cfg_rx_pkg::*;
#(
  parameter int FRAME_DATA = 16,
  parameter int START_BITS = 2,
  parameter int NUM_FRAMES = 8,
  parameter int SEL_W      = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  active,
  input  logic                  bit_in,
  output logic                  wr_en,
  output logic [SEL_W-1:0]      wr_idx,
  output logic [FRAME_DATA-1:0] wr_data,
  output logic                  mem_full
);
  localparam int FB    = frame_bits(START_BITS, FRAME_DATA);
  localparam int POS_W = $clog2(FB);

  logic [POS_W-1:0]      pos_q;
  logic [SEL_W-1:0]      idx_q;
  logic [FRAME_DATA-1:0] shift_q;
  logic                  frame_end;
  logic                  in_data;

  assign in_data   = pos_q >= POS_W'(START_BITS);
  assign frame_end = active && (pos_q == POS_W'(FB - 1));
  assign wr_en     = frame_end;
  assign wr_idx    = idx_q;
  assign wr_data   = {shift_q[FRAME_DATA-2:0], bit_in};
  assign mem_full  = frame_end && (idx_q == SEL_W'(NUM_FRAMES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
    end else if (active) begin
      if (frame_end) begin
        pos_q   <= '0;
        idx_q   <= idx_q + SEL_W'(1);
        shift_q <= '0;
      end else begin
        pos_q <= pos_q + POS_W'(1);
        if (in_data) shift_q <= {shift_q[FRAME_DATA-2:0], bit_in};
      end
    end
  end
endmodule

// File: rtl/cfg_frame_store.sv
module cfg_frame_store #(
  parameter int FRAME_DATA = 16,
  parameter int NUM_FRAMES = 8,
  parameter int SEL_W      = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SEL_W-1:0]      wr_idx,
  input  logic [FRAME_DATA-1:0] wr_data,
  input  logic [SEL_W-1:0]      rd_idx,
  output logic [FRAME_DATA-1:0] rd_data
);
  logic [FRAME_DATA-1:0] ent_q [NUM_FRAMES];

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                                 ent_q[g] <= '0;
      else if (wr_en && wr_idx == SEL_W'(g))      ent_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_FRAMES; i++)
      if (rd_idx == SEL_W'(i)) rd_data = ent_q[i];
  end
endmodule

// File: rtl/cfg_chain_rx.sv
module cfg_chain_rx
  import cfg_rx_pkg::*;
#(
  parameter int FRAME_DATA = 16,
  parameter int START_BITS = 2,
  parameter int NUM_FRAMES = 8,
  parameter int LEN_BITS   = 24,
  parameter int PRE_BITS   = 8,
  parameter logic [PRE_BITS-1:0] PREAMBLE = 8'hF2,
  localparam int SEL_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                  cclk,
  input  logic                  prog_n,
  input  logic                  sdi,
  input  logic [SEL_W-1:0]      rd_sel,
  output logic                  sdo,
  output logic                  done,
  output logic [FRAME_DATA-1:0] rd_frame
);
  rx_state_e             state_q, state_d;
  logic [LEN_BITS-1:0]   cnt_q, len_q;
  logic [LEN_BITS-1:0]   cnt_next, len_word;
  logic                  fwd_q;

  // Named internal events
  logic                  preamble_hit;
  logic                  length_done;
  logic                  short_len;
  logic                  count_hit;
  logic                  mem_full;
  logic                  load_active;
  logic                  wr_en;
  logic [SEL_W-1:0]      wr_idx;
  logic [FRAME_DATA-1:0] wr_data;

  assign cnt_next    = cnt_q + LEN_BITS'(1);
  assign len_word    = {len_q[LEN_BITS-2:0], sdi};
  assign length_done = (state_q == ST_LENGTH) && (cnt_next == LEN_BITS'(LEN_BITS));
  assign short_len   = len_word <= LEN_BITS'(LEN_BITS);
  assign count_hit   = (state_q == ST_LOAD || state_q == ST_PASS) && (cnt_next == len_q);
  assign load_active = state_q == ST_LOAD;

  cfg_preamble_det #(.PRE_BITS(PRE_BITS), .PATTERN(PREAMBLE)) u_pre (
    .clk(cclk), .rst_n(prog_n), .enable(state_q == ST_SEARCH),
    .bit_in(sdi), .hit(preamble_hit)
  );

  cfg_frame_loader #(
    .FRAME_DATA(FRAME_DATA), .START_BITS(START_BITS),
    .NUM_FRAMES(NUM_FRAMES), .SEL_W(SEL_W)
  ) u_load (
    .clk(cclk), .rst_n(prog_n), .active(load_active), .bit_in(sdi),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .mem_full(mem_full)
  );

  cfg_frame_store #(
    .FRAME_DATA(FRAME_DATA), .NUM_FRAMES(NUM_FRAMES), .SEL_W(SEL_W)
  ) u_store (
    .clk(cclk), .rst_n(prog_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_sel), .rd_data(rd_frame)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_SEARCH:   if (preamble_hit) state_d = ST_LENGTH;
      ST_LENGTH:   if (length_done)  state_d = short_len ? ST_FINISHED : ST_LOAD;
      ST_LOAD: begin
        if (count_hit)     state_d = ST_FINISHED;
        else if (mem_full) state_d = ST_PASS;
      end
      ST_PASS:     if (count_hit)    state_d = ST_FINISHED;
      ST_FINISHED: state_d = ST_FINISHED;
      default:     state_d = ST_SEARCH;
    endcase
  end

  always_ff @(posedge cclk) begin
    if (!prog_n) begin
      state_q <= ST_SEARCH;
      cnt_q   <= '0;
      len_q   <= '0;
      done    <= 1'b0;
      fwd_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      fwd_q   <= fwd_value(state_q, sdi);
      if (preamble_hit) cnt_q <= '0;
      if (state_q == ST_LENGTH) begin
        len_q <= len_word;
        cnt_q <= cnt_next;
      end else if (state_q == ST_LOAD || state_q == ST_PASS) begin
        cnt_q <= cnt_next;
      end
      if (state_d == ST_FINISHED) done <= 1'b1;
    end
  end

  // Output launched on the falling edge, half a clock after capture.
  always_ff @(negedge cclk) begin
    if (!prog_n) sdo <= 1'b1;
    else         sdo <= fwd_q;
  end
endmodule

// File: rtl/cfg_chain_rx_chk.sv
module cfg_chain_rx_chk
  import cfg_rx_pkg::*;
#(
  parameter int LEN_BITS = 24
) (
  input logic                cclk,
  input logic                prog_n,
  input logic                sdi,
  input logic                sdo,
  input logic                done,
  input rx_state_e           state_q,
  input logic [LEN_BITS-1:0] cnt_q,
  input logic [LEN_BITS-1:0] len_q,
  input logic                wr_en,
  input logic                mem_full,
  input logic                count_hit
);
  AST_FORWARD_FOLLOWS_INPUT: assert property (@(posedge cclk) disable iff (!prog_n)
    (state_q == ST_SEARCH || state_q == ST_LENGTH || state_q == ST_PASS) |=> (sdo == $past(sdi))); // R1

  AST_HIGH_WHILE_LOADING: assert property (@(posedge cclk) disable iff (!prog_n)
    (state_q == ST_LOAD) |=> sdo); // R5

  AST_WRITE_ONLY_LOADING: assert property (@(posedge cclk) disable iff (!prog_n)
    wr_en |-> (state_q == ST_LOAD)); // R5

  AST_COUNT_BELOW_LENGTH: assert property (@(posedge cclk) disable iff (!prog_n)
    (state_q == ST_LOAD || state_q == ST_PASS) |-> (cnt_q < len_q)); // R4

  AST_FULL_TO_PASS: assert property (@(posedge cclk) disable iff (!prog_n)
    (mem_full && !count_hit) |=> (state_q == ST_PASS)); // R6

  AST_DONE_STICKY: assert property (@(posedge cclk) disable iff (!prog_n)
    done |=> done); // R7

  AST_HIGH_AFTER_DONE: assert property (@(posedge cclk) disable iff (!prog_n)
    (state_q == ST_FINISHED) |=> sdo); // R7

  AST_RESET_CLEARS: assert property (@(posedge cclk)
    !prog_n |=> (state_q == ST_SEARCH && !done && cnt_q == '0)); // R8
endmodule

bind cfg_chain_rx cfg_chain_rx_chk #(.LEN_BITS(LEN_BITS)) u_chk (
  .cclk(cclk), .prog_n(prog_n), .sdi(sdi), .sdo(sdo), .done(done),
  .state_q(state_q), .cnt_q(cnt_q), .len_q(len_q), .wr_en(wr_en),
  .mem_full(mem_full), .count_hit(count_hit)
);

// File: tb/cfg_chain_rx_bench.sv
module cfg_chain_rx_bench;
  localparam int FD = 4;
  localparam int SB = 2;
  localparam int NF = 3;
  localparam int FB = FD + SB;
  localparam int LOCAL = NF * FB;
  localparam logic [7:0]  PRE  = 8'b1111_0010;
  localparam logic [7:0]  NEAR = 8'b1111_0011;
  localparam logic [11:0] TAIL = 12'b1111_0010_1111;

  logic       cclk = 1'b0;
  logic       prog_n = 1'b0;
  logic       sdi = 1'b1;
  logic [1:0] rd_sel = '0;
  logic       sdo;
  logic       done;
  logic [FD-1:0] rd_frame;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 cclk = ~cclk;

  cfg_chain_rx #(.FRAME_DATA(FD), .START_BITS(SB), .NUM_FRAMES(NF)) u_cfg_chain_rx (
    .cclk(cclk), .prog_n(prog_n), .sdi(sdi), .rd_sel(rd_sel),
    .sdo(sdo), .done(done), .rd_frame(rd_frame)
  );

  function automatic int dat(input int f, input int s);
    return (f * 5 + s * 3 + 9) & ((1 << FD) - 1);
  endfunction

  task automatic check(input int act, input int exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // One bit per clock: drive after a falling edge, observe after the next one.
  task automatic step(input logic b, input logic exp_o, input logic exp_d, input string tag);
    sdi = b;
    @(posedge cclk);
    @(negedge cclk);
    #1;
    check(int'(sdo), int'(exp_o), {tag, " sdo"});
    check(int'(done), int'(exp_d), {tag, " done"});
  endtask

  task automatic do_reset();
    sdi = 1'b1;
    prog_n = 1'b0;
    repeat (2) @(posedge cclk);
    @(negedge cclk);
    #1;
    check(int'(sdo), 1, "R8 reset sdo");
    check(int'(done), 0, "R8 reset done");
    for (int f = 0; f < NF; f++) begin
      rd_sel = 2'(f);
      #1;
      check(int'(rd_frame), 0, "R8 reset frame cleared");
    end
    prog_n = 1'b1;
  endtask

  task automatic run(input int len, input int seed, input bit near, input int stop_at);
    int pay;
    logic b;
    logic [23:0] lw;
    pay = (len > 24) ? len - 24 : 0;
    lw = 24'(len);
    do_reset();
    for (int i = 0; i < 8; i++) begin
      b = near ? NEAR[7-i] : 1'b1;
      step(b, b, 1'b0, "R2 lead forward");
    end
    for (int i = 0; i < 8; i++) step(PRE[7-i], PRE[7-i], 1'b0, "R2 preamble forward");
    for (int j = 0; j < 24; j++)
      step(lw[23-j], lw[23-j], (len <= 24) && (j == 23), "R3 R4 length");
    for (int p = 0; p < pay; p++) begin
      int f;
      int o;
      if (stop_at >= 0 && p == stop_at) return;
      f = p / FB;
      o = p % FB;
      if (f < NF) b = (o < SB) ? 1'b0 : 1'(dat(f, seed) >> (FD - 1 - (o - SB)));
      else        b = 1'((p * 13 + seed) >> 1);
      if (p < LOCAL) step(b, 1'b1, p == pay - 1, "R5 R10 loading");
      else           step(b, b, p == pay - 1, "R6 pass");
    end
    for (int i = 0; i < 12; i++) step(TAIL[11-i], 1'b1, 1'b1, "R7 after done");
    for (int f = 0; f < NF; f++) begin
      rd_sel = 2'(f);
      #1;
      if ((f + 1) * FB <= pay) check(int'(rd_frame), dat(f, seed), "R5 R9 frame");
      else                     check(int'(rd_frame), 0, "R9 R10 unwritten frame");
    end
  endtask

  initial begin
    @(negedge cclk);
    #1;
    for (int len = 20; len <= 48; len++) run(len, len, len % 2 == 1, -1);
    run(40, 7, 1'b0, 10);   // aborted mid-stream; next reset must clear frame 0 (R8)
    run(45, 11, 1'b1, -1);
    run(0, 3, 1'b0, -1);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge cclk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule